// File: doc/BRIEF.md
# Page-Mapped Logical-to-Physical Translator

This block turns logical block addresses into physical flash page numbers, one page per logical address. Every write goes out of place. It takes the page under a sequential append pointer, moves the pointer forward by one, stores the new mapping in a table, and marks the new page live in a per-page validity bitmap. If the logical address already had a page, that old page is marked stale. Reads look up the table and return the current page.

A small store of recently written logical addresses sits beside the table. A read of an address in that store is flagged as a hit, so the caller can serve it from its write buffer and skip the flash lookup. A read of an address that has never been written is flagged as unmapped.

Once the pointer has used every physical page, a full flag rises and further writes are refused. Reads are still served. A combinational probe port reports whether any given physical page holds live data.

Top module: `l2p_xlat`

## Requirements
- R1: After reset, rsp_valid and log_full are 0, every physical page reads stale on the probe, and every logical address reads as unmapped.
- R2: An accepted write is given the page equal to the append pointer, which starts at 0 and grows by one per accepted write. The write response returns that page with rsp_hit=0 and rsp_unmapped=0.
- R3: A read returns the page from the latest accepted write to that address. This includes a read accepted in the cycle right after the write.
- R4: A read of a never-written address returns rsp_unmapped=1, rsp_hit=0 and rsp_ppa=0.
- R5: After a write, chk_live is 1 for the newly assigned page. If the address was already mapped, chk_live is 0 for the page it held before.
- R6: A read returns rsp_hit=1, together with the mapped page, when its address is one of the logical addresses held in the 4-entry recent-write store.
- R7: A write to an address that is not in the store places it in the slot filled longest ago. A write to an address that is already in the store changes no slot and does not alter the order of replacement.
- R8: log_full is 1 exactly when the pointer equals the number of physical pages. While it is 1, req_ready is 0 for writes and 1 for reads.
- R9: rsp_valid pulses for exactly one cycle, in the cycle after each accepted request, and stays 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lba | input | LBA_W | Logical block address |
| rsp_valid | output | 1 | Response present |
| rsp_ppa | output | PPA_W | Physical page number |
| rsp_hit | output | 1 | Read address is in the recent-write store |
| rsp_unmapped | output | 1 | Read address has never been written |
| log_full | output | 1 | Append pointer has used every page |
| chk_ppa | input | PPA_W | Page to probe |
| chk_live | output | 1 | Probed page holds live data |

## Verification
A corrupted table entry appears on the very next read of that address as a wrong rsp_ppa. A stuck or skipped append pointer shows up one request later, in the page number returned for the next write. Validity bitmap faults are visible on the probe in the cycle after the write that caused them. An error in the replacement order of the recent-write store only shows after a later insertion evicts the wrong slot, so the bench rewrites a buffered address and then inserts a new one before it reads the store back.

// File: rtl/l2p_xlat.sv
module l2p_xlat #(
  parameter int LBA_W = 8,
  parameter int NPAGE = 512,
  parameter int BUF_N = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [LBA_W-1:0]         req_lba,
  output logic                     rsp_valid,
  output logic [$clog2(NPAGE)-1:0] rsp_ppa,
  output logic                     rsp_hit,
  output logic                     rsp_unmapped,
  output logic                     log_full,
  input  logic [$clog2(NPAGE)-1:0] chk_ppa,
  output logic                     chk_live
);
  localparam int NLBA  = 1 << LBA_W;
  localparam int PPA_W = $clog2(NPAGE);
  localparam int BI_W  = (BUF_N > 1) ? $clog2(BUF_N) : 1;

  logic [PPA_W-1:0] map_q [NLBA];
  logic [NLBA-1:0]  mapped_q;
  logic [NPAGE-1:0] live_q;
  logic [PPA_W:0]   nxt_q;
  logic [LBA_W-1:0] btag_q [BUF_N];
  logic [BUF_N-1:0] bval_q;
  logic [BI_W-1:0]  bptr_q;
  logic [BUF_N-1:0] bmatch;

  genvar gi;
  generate
    for (gi = 0; gi < BUF_N; gi++) begin : g_cmp
      assign bmatch[gi] = bval_q[gi] && (btag_q[gi] == req_lba);
    end
  endgenerate

  wire              buf_hit = |bmatch;
  wire [PPA_W-1:0]  wr_ppa  = nxt_q[PPA_W-1:0];
  wire [PPA_W-1:0]  old_ppa = map_q[req_lba];
  wire              was_map = mapped_q[req_lba];

  assign log_full  = (nxt_q == (PPA_W+1)'(NPAGE));
  assign req_ready = !(req_write && log_full);
  assign chk_live  = live_q[chk_ppa];

  wire acc    = req_valid && req_ready;
  wire wr_acc = acc && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mapped_q     <= '0;
      live_q       <= '0;
      nxt_q        <= '0;
      bval_q       <= '0;
      bptr_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_ppa      <= '0;
      rsp_hit      <= 1'b0;
      rsp_unmapped <= 1'b0;
    end else begin
      rsp_valid <= acc;
      if (acc) begin
        rsp_hit      <= !req_write && buf_hit;
        rsp_unmapped <= !req_write && !was_map;
        rsp_ppa      <= req_write ? wr_ppa : (was_map ? old_ppa : '0);
      end
      if (wr_acc) begin
        mapped_q[req_lba] <= 1'b1;
        if (was_map) live_q[old_ppa] <= 1'b0;
        live_q[wr_ppa] <= 1'b1;
        nxt_q <= nxt_q + 1'b1;
        if (!buf_hit) begin
          bval_q[bptr_q] <= 1'b1;
          bptr_q <= (bptr_q == BI_W'(BUF_N-1)) ? '0 : bptr_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_acc) begin
      map_q[req_lba] <= wr_ppa;
      if (!buf_hit) btag_q[bptr_q] <= req_lba;
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> nxt_q == $past(nxt_q) + 1'b1); // R2
  AST_NEW_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> live_q[$past(wr_ppa)]); // R5
  AST_OLD_STALE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && was_map) |=> !live_q[$past(old_ppa)]); // R5
  AST_UNMAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_unmapped) |-> (rsp_ppa == '0 && !rsp_hit)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    nxt_q <= (PPA_W+1)'(NPAGE)); // R8
  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    log_full |=> log_full); // R8
  AST_RSP_AFTER_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid); // R9
  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid); // R9
endmodule

// File: tb/l2p_xlat_bench.sv
`timescale 1ns/1ps
module l2p_xlat_bench;
  localparam int LBA_W = 8, NPAGE = 512, NLBA = 256, PPA_W = 9;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [LBA_W-1:0] req_lba = '0;
  logic [PPA_W-1:0] chk_ppa = '0;
  logic req_ready, rsp_valid, rsp_hit, rsp_unmapped, log_full, chk_live;
  logic [PPA_W-1:0] rsp_ppa;

  l2p_xlat u_l2p_xlat (.clk, .rst_n, .req_valid, .req_ready, .req_write, .req_lba,
    .rsp_valid, .rsp_ppa, .rsp_hit, .rsp_unmapped, .log_full, .chk_ppa, .chk_live);

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  int em [NLBA];
  bit emd [NLBA];
  bit ev [NPAGE];
  int enxt = 0;
  int fq [4];
  bit fv [4];
  int fp = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit in_fifo(input int lba);
    for (int i = 0; i < 4; i++) if (fv[i] && fq[i] == lba) return 1;
    return 0;
  endfunction

  task automatic req(input bit w, input int lba);
    bit full_exp, hit_e, unm_e;
    int ppa_e;
    @(negedge clk);
    chk("R9 idle rsp_valid", rsp_valid, 0);
    full_exp = (enxt == NPAGE);
    chk("R8 log_full", log_full, full_exp);
    req_write = w; req_lba = lba[LBA_W-1:0]; req_valid = 1;
    #0.5;
    chk("R8 req_ready", req_ready, !(w && full_exp));
    hit_e = !w && in_fifo(lba);
    unm_e = !w && !emd[lba];
    ppa_e = w ? enxt : (emd[lba] ? em[lba] : 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (w && full_exp) begin
      chk("R8 refused write no rsp", rsp_valid, 0);
      return;
    end
    chk("R9 rsp_valid", rsp_valid, 1);
    chk(w ? "R2 write ppa" : (unm_e ? "R4 unmapped ppa" : "R3 read ppa"), rsp_ppa, ppa_e);
    chk(unm_e ? "R4 hit" : "R6 hit", rsp_hit, hit_e);
    chk("R4 unmapped", rsp_unmapped, unm_e);
    if (w) begin
      if (emd[lba]) ev[em[lba]] = 0;
      em[lba] = enxt; emd[lba] = 1; ev[enxt] = 1; enxt++;
      if (!in_fifo(lba)) begin fq[fp] = lba; fv[fp] = 1; fp = (fp + 1) % 4; end
    end
  endtask

  task automatic sweep_live(input string tag);
    for (int p = 0; p < NPAGE; p++) begin
      chk_ppa = p[PPA_W-1:0];
      #0.1;
      chk(tag, chk_live, ev[p]);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 log_full", log_full, 0);
    sweep_live("R1 page stale");
    for (int l = 0; l < 8; l++) req(0, l * 37);
    // R7: rewrite of buffered LBA keeps slot order; LBA 14 then evicts 10
    req(1, 10); req(1, 11); req(1, 12); req(1, 13);
    req(0, 10);
    req(1, 10);
    req(1, 14);
    for (int l = 10; l <= 14; l++) req(0, l);
    sweep_live("R5 after rewrite");
    // R3 back to back write then read across all LBAs
    for (int l = 0; l < NLBA; l++) begin req(1, l); req(0, l); end
    sweep_live("R5 after sweep");
    for (int l = 0; l < NLBA; l++) req(0, l);
    for (int l = NLBA - 1; enxt < NPAGE; l--) req(1, l);
    chk("R8 full set", log_full, 1);
    sweep_live("R5 at full");
    req(1, 3);
    req(1, 200);
    for (int l = 0; l < NLBA; l += 17) req(0, l);
    req(0, 255);
    @(negedge clk);
    chk("R9 final idle", rsp_valid, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule